// File: doc/BRIEF.md
# Bridge I/O Window Decoder

This block decides whether a 16-bit I/O transaction should cross a bridge to the downstream link. Software programs a lower and an upper window register through a byte-wide configuration port. Each register has a 4-bit programmable field that sets address bits 15:12 of one bound. The lower bound always begins on a 4 KB boundary, and the upper bound always ends at the last byte of a 4 KB block. An I/O address is forwarded when it falls inside the inclusive range between the two bounds.

Both registers come out of reset with the lower bound above the upper bound. The window is therefore empty and no traffic passes until software programs it. A write commits on the clock edge that samples the strobe. Reads and the forward decision are combinational from the stored values, so the decoder adds no latency to the address path.

Top module: `iowin_decoder`

## Requirements
- R1: After reset, the lower-bound register (offset 0x1C) reads 0xF0 and the upper-bound register (offset 0x1D) reads 0x00.
- R2: A write with cfg_wr high at offset 0x1C or 0x1D stores cfg_wdata[7:4] into that register's field at the next rising clock edge. A read of that offset afterwards returns the new value in bits 7:4.
- R3: Bits 3:0 of both registers always read as zero, and the values written to those bits have no effect.
- R4: A read at any offset other than 0x1C and 0x1D returns 0x00. A write to any such offset changes neither register.
- R5: The lower bound is {field_lo, 12'h000}. With io_valid high, an address below it is not forwarded, and an address equal to it is forwarded when it is also at or below the upper bound.
- R6: The upper bound is {field_hi, 12'hFFF}. With io_valid high, an address above it is not forwarded, and an address equal to it is forwarded when it is also at or above the lower bound.
- R7: fwd is low whenever io_valid is low, whatever the address and the register contents.
- R8: When the lower field is greater than the upper field, no address is forwarded. This includes the state straight after reset.
- R9: cfg_rdata is 0x00 whenever cfg_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read enable |
| cfg_ofs | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| io_valid | input | 1 | Marks io_addr as an I/O transaction |
| io_addr | input | 16 | I/O transaction address |
| fwd | output | 1 | Route the transaction downstream |

## Verification
The only state in the block is the two stored fields. If a field holds a wrong value, the error shows in two places. A read of that offset returns the wrong value in the same cycle. The fwd output also changes at exactly the addresses where the window's bound crosses a 4 KB boundary. The bench covers every pair of the two fields. For each pair it places addresses on both sides of every 4 KB boundary and in the middle of each block. This lets a bad bound, a wrong fill of the low bits, or a comparison that is off by one appear as a mismatch of fwd on the next address applied after the register write lands.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  // Default geometry of the decoder
  localparam int unsigned IOW_ADDR_W = 16;
  localparam int unsigned IOW_REG_W  = 8;
  localparam int unsigned IOW_NIB_W  = 4;
  localparam int unsigned IOW_OFS_W  = 8;

  // Offsets and reset contents of the two window registers
  localparam logic [7:0] IOW_LO_OFS = 8'h1C;
  localparam logic [7:0] IOW_HI_OFS = 8'h1D;
  localparam logic [3:0] IOW_LO_RST = 4'hF;
  localparam logic [3:0] IOW_HI_RST = 4'h0;

  typedef enum logic [0:0] {
    WIN_LO = 1'b0,
    WIN_HI = 1'b1
  } win_sel_e;
endpackage

// File: rtl/iowin_reg.sv
module iowin_reg #(
  parameter int unsigned REG_W = 8,
  parameter int unsigned NIB_W = 4,
  parameter int unsigned OFS_W = 8,
  parameter logic [OFS_W-1:0] MY_OFS = '0,
  parameter logic [NIB_W-1:0] RST_NIB = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             rd,
  input  logic [OFS_W-1:0] ofs,
  input  logic [NIB_W-1:0] wnib,
  output logic [NIB_W-1:0] field,
  output logic [REG_W-1:0] rdata
);
  localparam int unsigned PAD_W = REG_W - NIB_W;

  logic sel;
  assign sel = (ofs == MY_OFS);

  always_ff @(posedge clk) begin
    if (rst) begin
      field <= RST_NIB;
    end else if (wr && sel) begin
      field <= wnib;
    end
  end

  // Reserved low bits read back as zero
  assign rdata = (rd && sel) ? {field, {PAD_W{1'b0}}} : '0;
endmodule

// File: rtl/iowin_cmp.sv
module iowin_cmp #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned NIB_W  = 4
) (
  input  logic [NIB_W-1:0]  lo_nib,
  input  logic [NIB_W-1:0]  hi_nib,
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int unsigned LOW_W = ADDR_W - NIB_W;

  logic [ADDR_W-1:0] lo_bound;
  logic [ADDR_W-1:0] hi_bound;

  // Lower bound aligned down, upper bound filled to the block top
  assign lo_bound = {lo_nib, {LOW_W{1'b0}}};
  assign hi_bound = {hi_nib, {LOW_W{1'b1}}};

  // An inverted pair of bounds yields an empty window on its own
  assign hit = valid && (addr >= lo_bound) && (addr <= hi_bound);
endmodule

// File: rtl/iowin_decoder.sv
module iowin_decoder
  import iowin_pkg::*;
#(
  parameter int unsigned ADDR_W = IOW_ADDR_W,
  parameter int unsigned REG_W  = IOW_REG_W,
  parameter int unsigned NIB_W  = IOW_NIB_W,
  parameter int unsigned OFS_W  = IOW_OFS_W,
  parameter logic [OFS_W-1:0] LO_OFS = OFS_W'(IOW_LO_OFS),
  parameter logic [OFS_W-1:0] HI_OFS = OFS_W'(IOW_HI_OFS),
  parameter logic [NIB_W-1:0] LO_RST = NIB_W'(IOW_LO_RST),
  parameter logic [NIB_W-1:0] HI_RST = NIB_W'(IOW_HI_RST)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [OFS_W-1:0]  cfg_ofs,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              io_valid,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              fwd
);
  localparam int unsigned NREG  = 2;
  localparam int unsigned PAD_W = REG_W - NIB_W;

  logic [NIB_W-1:0] wnib;
  logic [PAD_W-1:0] unused_wlow;
  logic [NIB_W-1:0] fields [NREG];
  logic [REG_W-1:0] rd_each [NREG];

  assign wnib        = cfg_wdata[REG_W-1:PAD_W];
  assign unused_wlow = cfg_wdata[PAD_W-1:0];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [OFS_W-1:0] OFS_I = (i == int'(WIN_LO)) ? LO_OFS : HI_OFS;
    localparam logic [NIB_W-1:0] RST_I = (i == int'(WIN_LO)) ? LO_RST : HI_RST;
    iowin_reg #(
      .REG_W  (REG_W),
      .NIB_W  (NIB_W),
      .OFS_W  (OFS_W),
      .MY_OFS (OFS_I),
      .RST_NIB(RST_I)
    ) u_reg (
      .clk  (clk),
      .rst  (rst),
      .wr   (cfg_wr),
      .rd   (cfg_rd),
      .ofs  (cfg_ofs),
      .wnib (wnib),
      .field(fields[i]),
      .rdata(rd_each[i])
    );
  end

  // At most one register is selected; unmatched offsets leave zero
  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      cfg_rdata = cfg_rdata | rd_each[i];
    end
  end

  iowin_cmp #(
    .ADDR_W(ADDR_W),
    .NIB_W (NIB_W)
  ) u_cmp (
    .lo_nib(fields[WIN_LO]),
    .hi_nib(fields[WIN_HI]),
    .valid (io_valid),
    .addr  (io_addr),
    .hit   (fwd)
  );
endmodule

// File: rtl/iowin_decoder_chk.sv
module iowin_decoder_chk #(
  parameter int unsigned REG_W = 8,
  parameter int unsigned NIB_W = 4,
  parameter int unsigned OFS_W = 8,
  parameter logic [OFS_W-1:0] LO_OFS = 8'h1C,
  parameter logic [OFS_W-1:0] HI_OFS = 8'h1D,
  parameter logic [NIB_W-1:0] LO_RST = 4'hF,
  parameter logic [NIB_W-1:0] HI_RST = 4'h0
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_wr,
  input logic             cfg_rd,
  input logic [OFS_W-1:0] cfg_ofs,
  input logic [NIB_W-1:0] wnib,
  input logic [REG_W-1:0] cfg_rdata,
  input logic             io_valid,
  input logic             fwd
);
  localparam int unsigned PAD_W = REG_W - NIB_W;

  // R7
  no_fwd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !io_valid |-> !fwd);

  // R3
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_rd |-> (cfg_rdata[PAD_W-1:0] == '0));

  // R4
  other_ofs_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && cfg_ofs != LO_OFS && cfg_ofs != HI_OFS) |-> (cfg_rdata == '0));

  // R9
  no_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_rd |-> (cfg_rdata == '0));

  // R2
  lo_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_ofs == LO_OFS) |=>
      (!(cfg_rd && cfg_ofs == LO_OFS) || cfg_rdata[REG_W-1:PAD_W] == $past(wnib)));

  // R2
  hi_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_ofs == HI_OFS) |=>
      (!(cfg_rd && cfg_ofs == HI_OFS) || cfg_rdata[REG_W-1:PAD_W] == $past(wnib)));

  // R1
  lo_reset_val_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && cfg_rd && cfg_ofs == LO_OFS) |-> (cfg_rdata == {LO_RST, {PAD_W{1'b0}}}));

  // R1
  hi_reset_val_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && cfg_rd && cfg_ofs == HI_OFS) |-> (cfg_rdata == {HI_RST, {PAD_W{1'b0}}}));

  // R8
  empty_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !fwd);
endmodule

bind iowin_decoder iowin_decoder_chk #(
  .REG_W (REG_W),
  .NIB_W (NIB_W),
  .OFS_W (OFS_W),
  .LO_OFS(LO_OFS),
  .HI_OFS(HI_OFS),
  .LO_RST(LO_RST),
  .HI_RST(HI_RST)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_wr   (cfg_wr),
  .cfg_rd   (cfg_rd),
  .cfg_ofs  (cfg_ofs),
  .wnib     (wnib),
  .cfg_rdata(cfg_rdata),
  .io_valid (io_valid),
  .fwd      (fwd)
);

// File: tb/iowin_decoder_tb.sv
module iowin_decoder_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr;
  logic        cfg_rd;
  logic [7:0]  cfg_ofs;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic        io_valid;
  logic [15:0] io_addr;
  logic        fwd;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  iowin_decoder u_dut (
    .clk      (clk),
    .rst      (rst),
    .cfg_wr   (cfg_wr),
    .cfg_rd   (cfg_rd),
    .cfg_ofs  (cfg_ofs),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .io_valid (io_valid),
    .io_addr  (io_addr),
    .fwd      (fwd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] ofs, input logic [7:0] data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_ofs = ofs; cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] ofs, output logic [7:0] data);
    cfg_rd = 1'b1; cfg_ofs = ofs;
    #1 data = cfg_rdata;
    cfg_rd = 1'b0;
    #1;
  endtask

  function automatic logic exp_fwd(input logic v, input logic [15:0] a,
                                   input logic [3:0] lo, input logic [3:0] hi);
    int unsigned lb, ub;
    lb = int'(lo) * 4096;
    ub = int'(hi) * 4096 + 4095;
    return v && (int'(a) >= lb) && (int'(a) <= ub);
  endfunction

  task automatic probe(input string req, input logic v, input logic [15:0] a,
                       input logic [3:0] lo, input logic [3:0] hi);
    io_valid = v; io_addr = a;
    #1 check(req, 32'(fwd), 32'(exp_fwd(v, a, lo, hi)));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    rst = 1'b1; cfg_wr = 1'b0; cfg_rd = 1'b0; cfg_ofs = '0; cfg_wdata = '0;
    io_valid = 1'b0; io_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset contents
    rd_reg(8'h1C, rv); check("R1 lo reset", 32'(rv), 32'hF0);
    rd_reg(8'h1D, rv); check("R1 hi reset", 32'(rv), 32'h00);

    // R8 empty window after reset: probe every block edge
    for (int n = 0; n < 16; n++) begin
      probe("R8 reset empty", 1'b1, 16'(n * 4096), 4'hF, 4'h0);
      probe("R8 reset empty", 1'b1, 16'(n * 4096 + 4095), 4'hF, 4'h0);
    end

    // R9 no read -> zero
    cfg_rd = 1'b0; cfg_ofs = 8'h1C;
    #1 check("R9 idle rdata", 32'(cfg_rdata), 32'h0);

    // R2, R3 write with low bits set, readback has low nibble zero
    wr_reg(8'h1C, 8'h3B);
    wr_reg(8'h1D, 8'hA7);
    rd_reg(8'h1C, rv); check("R2 R3 lo readback", 32'(rv), 32'h30);
    rd_reg(8'h1D, rv); check("R2 R3 hi readback", 32'(rv), 32'hA0);

    // R2 takes effect only at the edge: before the edge old value remains
    @(negedge clk);
    cfg_wr = 1'b1; cfg_ofs = 8'h1C; cfg_wdata = 8'h50;
    cfg_rd = 1'b1;
    #1 check("R2 before edge", 32'(cfg_rdata), 32'h30);
    @(posedge clk);
    #1 check("R2 after edge", 32'(cfg_rdata), 32'h50);
    cfg_wr = 1'b0; cfg_rd = 1'b0;

    // R4 other offsets: read zero, writes ignored
    for (int o = 0; o < 256; o++) begin
      if (o != 8'h1C && o != 8'h1D) begin
        wr_reg(8'(o), 8'hFF);
        rd_reg(8'(o), rv); check("R4 other read", 32'(rv), 32'h0);
      end
    end
    rd_reg(8'h1C, rv); check("R4 lo kept", 32'(rv), 32'h50);
    rd_reg(8'h1D, rv); check("R4 hi kept", 32'(rv), 32'hA0);

    // R7 io_valid low with wide window
    wr_reg(8'h1C, 8'h00);
    wr_reg(8'h1D, 8'hF0);
    for (int n = 0; n < 16; n++) begin
      probe("R7 idle no fwd", 1'b0, 16'(n * 4096 + 2048), 4'h0, 4'hF);
    end

    // R5 R6 R8 exhaustive sweep over both fields
    for (int lo = 0; lo < 16; lo++) begin
      for (int hi = 0; hi < 16; hi++) begin
        wr_reg(8'h1C, 8'(lo << 4) | 8'h0C);
        wr_reg(8'h1D, 8'(hi << 4) | 8'h03);
        for (int n = 0; n < 16; n++) begin
          string tag;
          tag = (lo > hi) ? "R8 inverted empty" : "R5 lo edge";
          probe(tag, 1'b1, 16'(n * 4096), 4'(lo), 4'(hi));
          tag = (lo > hi) ? "R8 inverted empty" : "R6 hi edge";
          probe(tag, 1'b1, 16'(n * 4096 + 4095), 4'(lo), 4'(hi));
          probe("R5 R6 mid block", 1'b1, 16'(n * 4096 + 1234), 4'(lo), 4'(hi));
        end
        probe("R7 idle in sweep", 1'b0, 16'(lo * 4096), 4'(lo), 4'(hi));
      end
    end
    io_valid = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule